// File: doc/BRIEF.md
# Peak Overload Detector with Retriggerable Hold

This block watches a stereo stream of filtered audio samples and raises a flag when the signal comes close to digital full scale. Each sample pair arrives with a valid strobe on the system clock and carries 20-bit signed words. Every word is first clamped to the legal 18-bit signed range. The clamped pair is registered and passed on, together with a delayed strobe, to the serial output stage.

The clamped magnitudes are compared with a fixed threshold that lies about 1 dB below full scale. A crossing on either channel loads a hold counter. While that counter is non-zero the overload flag stays high. Every new crossing reloads the counter, so a sustained overload keeps the flag high for as long as the crossings last. A standby input forces the flag low at once and empties the counter.

Top module: `ovl_peak_detect`

## Requirements
- R1: After reset, ovl_o, smp_valid_o, left_o and right_o are all zero.
- R2: A sample whose valid_i is high is clamped to the range -131072..131071: values above the range give 131071, values below it give -131072, and values inside it pass unchanged. The clamped pair appears on left_o/right_o with smp_valid_o high one clock after the sample is taken.
- R3: When valid_i is low, left_o and right_o keep their previous values and smp_valid_o is low.
- R4: A clamped sample counts as a crossing when its magnitude is strictly greater than 116508. The values +116508 and -116508 do not cross. The values +116509, -116509 and a clamped -131072 do cross.
- R5: A crossing on the left channel, on the right channel or on both sets the flag in the same way.
- R6: ovl_o goes high two clocks after a crossing sample is taken. It then stays high for exactly HOLD_CYCLES clocks.
- R7: A crossing while the flag is already high restarts the hold, so the flag stays high for HOLD_CYCLES clocks after the newest crossing.
- R8: Samples with valid_i low are never evaluated for a crossing.
- R9: While standby_i is high, ovl_o is low in the same cycle and the hold counter is cleared. Crossings during standby are ignored, and the flag stays low after standby ends until a new crossing occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Forces the flag low and clears the hold |
| valid_i | input | 1 | Sample pair strobe |
| left_i | input | IN_W | Left sample, signed |
| right_i | input | IN_W | Right sample, signed |
| smp_valid_o | output | 1 | Strobe for the clamped pair |
| left_o | output | OUT_W | Clamped left sample |
| right_o | output | OUT_W | Clamped right sample |
| ovl_o | output | 1 | Overload flag |

## Verification
The clamped pair and its strobe are due one clock after the sample is taken. The flag rises one clock after that, and it falls HOLD_CYCLES clocks after it rose, unless a restart or standby intervenes. The bench drives inputs on falling edges. It samples the clamped outputs one falling edge after the sample and the flag two falling edges after it, and it measures the hold by counting falling edges with the flag high. Standby is checked a short delay after its falling-edge change, because it acts without a register.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/ovl_sat.sv
module ovl_sat #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [IN_W-1:0]  data_i,
  output logic signed [OUT_W-1:0] data_o
);
  localparam int MAX_I = 2**(OUT_W-1) - 1;
  localparam int MIN_I = -(2**(OUT_W-1));
  localparam logic signed [IN_W-1:0] MAX_V = IN_W'(MAX_I);
  localparam logic signed [IN_W-1:0] MIN_V = IN_W'(MIN_I);

  logic signed [OUT_W-1:0] clip;

  always_comb begin
    if (data_i > MAX_V)      clip = MAX_V[OUT_W-1:0];
    else if (data_i < MIN_V) clip = MIN_V[OUT_W-1:0];
    else                     clip = data_i[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (valid_i) data_o <= clip;
  end

  a_r2_pass_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i <= MAX_V && data_i >= MIN_V) |=> data_o == $past(data_i[OUT_W-1:0]));
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: rtl/ovl_cmp.sv
module ovl_cmp #(
  parameter int W      = 18,
  parameter int THRESH = 116508
) (
  input  logic signed [W-1:0] smp_i,
  output logic                over_o
);
  localparam logic signed [W:0] THR_V = (W+1)'(THRESH);

  logic signed [W:0] ext, neg;

  // widen first so the most negative value negates without wrap
  always_comb begin
    ext    = (W+1)'(smp_i);
    neg    = -ext;
    over_o = (ext > THR_V) || (neg > THR_V);
  end
endmodule

// File: rtl/ovl_hold.sv
module ovl_hold #(
  parameter int HOLD_CYCLES = 131072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (load_i)       cnt_q <= HOLD_V;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> cnt_q == HOLD_V);
  a_r6_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && busy_o) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r6_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !busy_o) |=> !busy_o);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_o);
endmodule

// File: rtl/ovl_peak_detect.sv
module ovl_peak_detect
  import ovl_pkg::*;
#(
  parameter int IN_W        = 20,
  parameter int OUT_W       = 18,
  parameter int THRESH      = 116508,
  parameter int HOLD_CYCLES = 131072
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    standby_i,
  input  logic                    valid_i,
  input  logic signed [IN_W-1:0]  left_i,
  input  logic signed [IN_W-1:0]  right_i,
  output logic                    smp_valid_o,
  output logic signed [OUT_W-1:0] left_o,
  output logic signed [OUT_W-1:0] right_o,
  output logic                    ovl_o
);
  logic signed [IN_W-1:0]  din  [NUM_CH];
  logic signed [OUT_W-1:0] dsat [NUM_CH];
  logic [NUM_CH-1:0]       over;
  logic                    valid_q, hit, busy;

  assign din[CH_LEFT]  = left_i;
  assign din[CH_RIGHT] = right_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ovl_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
      .data_i(din[c]), .data_o(dsat[c]));
    ovl_cmp #(.W(OUT_W), .THRESH(THRESH)) u_cmp (
      .smp_i(dsat[c]), .over_o(over[c]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  // only a freshly registered pair is judged
  assign hit = valid_q & (|over) & ~standby_i;

  ovl_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(standby_i),
    .load_i(hit), .busy_o(busy));

  assign smp_valid_o = valid_q;
  assign left_o      = dsat[CH_LEFT];
  assign right_o     = dsat[CH_RIGHT];
  assign ovl_o       = busy & ~standby_i;

  a_r8_no_idle_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_q && !ovl_o && !standby_i) |=> !ovl_o);
  a_r6_rise_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && |over && !standby_i) |=> busy);
endmodule

// File: tb/ovl_peak_detect_tb.sv
module ovl_peak_detect_tb;
  localparam int HOLD = 16;
  localparam int THR  = 116508;

  logic clk = 1'b0, rst_n = 1'b0, stby = 1'b0, vld = 1'b0;
  logic signed [19:0] l_in = '0, r_in = '0;
  logic sv;
  logic signed [17:0] l_out, r_out;
  logic ovl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ovl_peak_detect #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(stby), .valid_i(vld),
    .left_i(l_in), .right_i(r_in), .smp_valid_o(sv),
    .left_o(l_out), .right_o(r_out), .ovl_o(ovl));

  function automatic int clampv(int v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  function automatic bit crosses(int v);
    int c = clampv(v);
    return (c > THR) || (-c > THR);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clear();
    for (int i = 0; i < HOLD + 4 && ovl; i++) @(negedge clk);
  endtask

  // drive one pair; return at the falling edge where the flag is due
  task automatic send(int lv, int rv);
    @(negedge clk);
    l_in = 20'(lv); r_in = 20'(rv); vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk("R2 valid", int'(sv), 1);
    chk("R2 left", int'(l_out), clampv(lv));
    chk("R2 right", int'(r_out), clampv(rv));
    @(negedge clk);
  endtask

  task automatic hold_len(string req, int exp);
    int n = 0;
    while (ovl && n < 4 * HOLD) begin n++; @(negedge clk); end
    chk(req, n, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    // R1 reset state
    chk("R1 ovl", int'(ovl), 0);
    chk("R1 valid", int'(sv), 0);
    chk("R1 left", int'(l_out), 0);
    chk("R1 right", int'(r_out), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R4 boundary values on each channel
    begin
      int bv[7] = '{THR, -THR, THR + 1, -THR - 1, -131072, 131071, -200000};
      foreach (bv[i]) begin
        wait_clear();
        send(bv[i], 0);
        chk("R4 left edge", int'(ovl), int'(crosses(bv[i])));
        wait_clear();
        send(0, bv[i]);
        chk("R4 right edge", int'(ovl), int'(crosses(bv[i])));
      end
    end

    // R2/R4/R5 sweep over both channels
    for (int v = -140000; v <= 140000; v += 1873) begin
      wait_clear();
      send(v, -v / 3);
      chk("R5 sweep", int'(ovl), int'(crosses(v) || crosses(-v / 3)));
    end

    // R5 both channels together
    wait_clear();
    send(150000, -150000);
    chk("R5 both", int'(ovl), 1);

    // R6 hold length
    wait_clear();
    send(THR + 5, 0);
    chk("R6 rise", int'(ovl), 1);
    hold_len("R6 hold", HOLD);

    // R7 restart during hold
    wait_clear();
    send(0, -THR - 9);
    repeat (7) @(negedge clk);
    send(THR + 2, 0);
    chk("R7 still high", int'(ovl), 1);
    hold_len("R7 restarted hold", HOLD);

    // R3/R8 samples without strobe
    wait_clear();
    send(1234, -4321);
    @(negedge clk);
    l_in = 20'sd150000; r_in = -20'sd150000; vld = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 no flag", int'(ovl), 0);
    chk("R3 left held", int'(l_out), 1234);
    chk("R3 right held", int'(r_out), -4321);
    chk("R3 strobe low", int'(sv), 0);

    // R9 standby
    send(THR + 100, 0);
    chk("R9 pre", int'(ovl), 1);
    stby = 1'b1;
    #1;
    chk("R9 immediate low", int'(ovl), 0);
    send(-131072, 131071);
    chk("R9 ignored in standby", int'(ovl), 0);
    stby = 1'b0;
    #1;
    chk("R9 cleared after", int'(ovl), 0);
    repeat (3) @(negedge clk);
    chk("R9 stays low", int'(ovl), 0);
    send(THR + 1, 0);
    chk("R9 new crossing", int'(ovl), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule